// File: doc/BRIEF.md
# Pin-Change Interrupt GPIO Port

An eight-pin general-purpose I/O port reached over a simple synchronous register bus. Each pin can be a software-driven output, a sampled input, or handed over to a companion peripheral. When a pin is handed over, its direction bit picks whether the peripheral drives the pad or listens to it. Each pin has a pull control whose polarity comes from the output register bit. A pin that is not handed over keeps the peripheral-side input frozen at its last value.

Every pad input passes through a two-flop synchronizer. A per-pin interrupt flag sets when the exclusive-OR of the pin's edge-polarity bit and its synchronized input rises. The flags stay set until software writes them, and software may also set them. One request line is raised while any enabled flag is pending. A vector register reports the lowest enabled pending pin as 2n+2, or 0 when none is pending. Reading the vector register clears that one flag, so a handler can dispatch through a jump table and acknowledge in the same access.

Register word addresses on `bus_addr_i`: 0 input (read-only), 1 output, 2 direction, 3 function select, 4 pull enable, 5 edge polarity, 6 interrupt enable, 7 interrupt flags, 8 vector (read-only). Eight-bit registers occupy data bits 7:0 and read back zero-extended. A read is an access with `bus_en_i`=1 and `bus_we_i`=0. `bus_rdata_o` is combinational in that cycle, and any side effect takes place at the next rising clock edge.

Top module: `gpio_pcint_port`

## Requirements
- R1: After reset every register at addresses 1 to 7 reads 0, the vector (address 8) reads 0, and `pad_out_o`, `pad_oe_o`, `pad_pull_en_o`, `pad_pull_up_o`, `periph_in_o` and `irq_o` are 0.
- R2: With function select (address 3) bit 0 for a pin, `pad_oe_o` equals the direction bit (address 2) and `pad_out_o` equals the output register bit (address 1). Registers at addresses 1 to 6 read back the low 8 bits of what was written.
- R3: With function select bit 1, `pad_out_o` takes `periph_out_i` for that pin and `pad_oe_o` still follows the direction bit. `periph_in_o` tracks the synchronized pin.
- R4: While function select bit is 0, `periph_in_o` for that pin holds its last value.
- R5: `pad_pull_en_o` equals the pull-enable register (address 4) whatever the direction, and `pad_pull_up_o` equals the output register: 1 means pull up, 0 means pull down.
- R6: The input register (address 0) shows each pad after two clock edges of synchronization, and it stays readable when function select is 1.
- R7: A flag bit (address 7) sets when (edge polarity bit XOR synchronized input) goes from 0 to 1. Polarity 0 selects rising and polarity 1 falling pad edges. A write to the polarity register alone can cause this, and output mode does not block it.
- R8: A pin with function select 1 never sets its flag from the pad.
- R9: A write to the flag register replaces the flags: a 1 sets and a 0 clears.
- R10: `irq_o` is 1 exactly while some bit has both flag and enable (address 6) set.
- R11: The vector register reads 2n+2 for the lowest n with flag and enable both set, or 0 if there is none. Reading it clears exactly flag n.
- R12: When a hardware set and a software clear of the same flag fall in one cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_en_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 write, 0 read |
| bus_addr_i | input | 4 | Register word address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, valid during a read access |
| pad_in_i | input | 8 | Pad input levels |
| pad_out_o | output | 8 | Pad output value |
| pad_oe_o | output | 8 | Pad output enable |
| pad_pull_en_o | output | 8 | Weak pull enable |
| pad_pull_up_o | output | 8 | Pull direction, 1 up |
| periph_out_i | input | 8 | Peripheral output values |
| periph_in_o | output | 8 | Peripheral-side input values |
| irq_o | output | 1 | Interrupt request |

## Verification
A stale edge-history bit produces either a spurious flag or a lost one. This shows on the flag register and `irq_o` one edge after the synchronizer output or the polarity register changes. A wrong priority choice or wrong acknowledge shows on the very next vector read, as a wrong code or a wrong surviving flag. Mux faults show on the pad outputs in the cycle after the configuration write. Faults in the frozen peripheral input show when function select is dropped and the pad then moves.

// File: rtl/gpio_pcint_pkg.sv
package gpio_pcint_pkg;
  localparam int unsigned REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    ADDR_IN   = 4'd0,
    ADDR_OUT  = 4'd1,
    ADDR_DIR  = 4'd2,
    ADDR_FSEL = 4'd3,
    ADDR_PULL = 4'd4,
    ADDR_EDGE = 4'd5,
    ADDR_IE   = 4'd6,
    ADDR_FLAG = 4'd7,
    ADDR_VEC  = 4'd8
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] out_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] fsel_i,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] periph_out_i,
  output logic [W-1:0] pad_out_o,
  output logic [W-1:0] pad_oe_o,
  output logic [W-1:0] periph_in_o
);
  for (genvar b = 0; b < W; b++) begin : g_pin
    logic hold_q;

    assign pad_out_o[b] = fsel_i[b] ? periph_out_i[b] : out_i[b];
    assign pad_oe_o[b]  = dir_i[b];

    // peripheral sees the pin only while it owns it
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        hold_q <= 1'b0;
      else if (fsel_i[b]) hold_q <= pin_i[b];
    end

    assign periph_in_o[b] = hold_q;
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int unsigned W  = 8,
  parameter int unsigned VW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  pin_i,
  input  logic [W-1:0]  edge_i,
  input  logic [W-1:0]  fsel_i,
  input  logic [W-1:0]  ie_i,
  input  logic          flag_wr_i,
  input  logic [W-1:0]  flag_wdata_i,
  input  logic          vec_rd_i,
  output logic [W-1:0]  flag_o,
  output logic [W-1:0]  rise_o,
  output logic [VW-1:0] vec_o,
  output logic          irq_o
);
  logic [W-1:0] trig, trig_q, flag_q, flag_d, pend, ack_oh;

  assign trig   = edge_i ^ pin_i;
  assign rise_o = trig & ~trig_q & ~fsel_i;
  assign pend   = flag_q & ie_i;

  // descending scan: lowest pending bit is assigned last
  always_comb begin
    vec_o  = '0;
    ack_oh = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (pend[i]) begin
        vec_o     = VW'(2 * i + 2);
        ack_oh    = '0;
        ack_oh[i] = 1'b1;
      end
    end
  end

  always_comb begin
    flag_d = flag_q;
    if (flag_wr_i) flag_d = flag_wdata_i;
    if (vec_rd_i)  flag_d = flag_d & ~ack_oh;
    flag_d = flag_d | rise_o;  // hardware set wins
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= '0;
      flag_q <= '0;
    end else begin
      trig_q <= trig;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = |pend;
endmodule

// File: rtl/gpio_pcint_port.sv
module gpio_pcint_port
  import gpio_pcint_pkg::*;
#(
  parameter int unsigned W        = 8,
  parameter int unsigned DW       = 16,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [REG_AW-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  input  logic [W-1:0]      pad_in_i,
  output logic [W-1:0]      pad_out_o,
  output logic [W-1:0]      pad_oe_o,
  output logic [W-1:0]      pad_pull_en_o,
  output logic [W-1:0]      pad_pull_up_o,
  input  logic [W-1:0]      periph_out_i,
  output logic [W-1:0]      periph_in_o,
  output logic              irq_o
);
  logic [W-1:0] out_q, dir_q, fsel_q, pull_q, edge_q, ie_q;
  logic [W-1:0] sync_in, flag_q, edge_rise;
  logic [DW-1:0] vec_val;
  logic wr, rd, flag_wr, vec_rd;
  logic wdata_unused;

  assign wr      = bus_en_i & bus_we_i;
  assign rd      = bus_en_i & ~bus_we_i;
  assign flag_wr = wr & (bus_addr_i == ADDR_FLAG);
  assign vec_rd  = rd & (bus_addr_i == ADDR_VEC);
  assign wdata_unused = ^bus_wdata_i[DW-1:W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      dir_q  <= '0;
      fsel_q <= '0;
      pull_q <= '0;
      edge_q <= '0;
      ie_q   <= '0;
    end else if (wr) begin
      case (bus_addr_i)
        ADDR_OUT:  out_q  <= bus_wdata_i[W-1:0];
        ADDR_DIR:  dir_q  <= bus_wdata_i[W-1:0];
        ADDR_FSEL: fsel_q <= bus_wdata_i[W-1:0];
        ADDR_PULL: pull_q <= bus_wdata_i[W-1:0];
        ADDR_EDGE: edge_q <= bus_wdata_i[W-1:0];
        ADDR_IE:   ie_q   <= bus_wdata_i[W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (rd) begin
      case (bus_addr_i)
        ADDR_IN:   bus_rdata_o = DW'(sync_in);
        ADDR_OUT:  bus_rdata_o = DW'(out_q);
        ADDR_DIR:  bus_rdata_o = DW'(dir_q);
        ADDR_FSEL: bus_rdata_o = DW'(fsel_q);
        ADDR_PULL: bus_rdata_o = DW'(pull_q);
        ADDR_EDGE: bus_rdata_o = DW'(edge_q);
        ADDR_IE:   bus_rdata_o = DW'(ie_q);
        ADDR_FLAG: bus_rdata_o = DW'(flag_q);
        ADDR_VEC:  bus_rdata_o = vec_val;
        default:   bus_rdata_o = '0;
      endcase
    end
  end

  gpio_sync #(.W(W), .STAGES(SYNC_LEN)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (sync_in)
  );

  gpio_pin_mux #(.W(W)) u_mux (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .out_i       (out_q),
    .dir_i       (dir_q),
    .fsel_i      (fsel_q),
    .pin_i       (sync_in),
    .periph_out_i(periph_out_i),
    .pad_out_o   (pad_out_o),
    .pad_oe_o    (pad_oe_o),
    .periph_in_o (periph_in_o)
  );

  gpio_irq_ctrl #(.W(W), .VW(DW)) u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pin_i       (sync_in),
    .edge_i      (edge_q),
    .fsel_i      (fsel_q),
    .ie_i        (ie_q),
    .flag_wr_i   (flag_wr),
    .flag_wdata_i(bus_wdata_i[W-1:0]),
    .vec_rd_i    (vec_rd),
    .flag_o      (flag_q),
    .rise_o      (edge_rise),
    .vec_o       (vec_val),
    .irq_o       (irq_o)
  );

  assign pad_pull_en_o = pull_q;
  assign pad_pull_up_o = out_q;
endmodule

// File: rtl/gpio_pcint_chk.sv
module gpio_pcint_chk
  import gpio_pcint_pkg::*;
#(
  parameter int unsigned W  = 8,
  parameter int unsigned DW = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_en_i,
  input logic              bus_we_i,
  input logic [REG_AW-1:0] bus_addr_i,
  input logic [DW-1:0]     bus_wdata_i,
  input logic [W-1:0]      pad_oe_o,
  input logic [W-1:0]      periph_in_o,
  input logic              irq_o,
  input logic [W-1:0]      fsel_q,
  input logic [W-1:0]      flag_q,
  input logic [W-1:0]      edge_rise,
  input logic [DW-1:0]     vec_val
);
  logic dir_wr, flag_wr, vec_rd;
  assign dir_wr  = bus_en_i && bus_we_i && (bus_addr_i == ADDR_DIR);
  assign flag_wr = bus_en_i && bus_we_i && (bus_addr_i == ADDR_FLAG);
  assign vec_rd  = bus_en_i && !bus_we_i && (bus_addr_i == ADDR_VEC);

  AST_OE_FOLLOWS_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_wr |=> pad_oe_o == $past(bus_wdata_i[W-1:0])); // R2

  AST_PERIPH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((periph_in_o ^ $past(periph_in_o)) & ~$past(fsel_q)) == '0); // R4

  AST_FSEL_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_wr |=> (flag_q & ~$past(flag_q) & $past(fsel_q)) == '0); // R8

  AST_IRQ_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (vec_val != '0)); // R10

  AST_VEC_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_val[0] == 1'b0) && (vec_val <= DW'(2 * W))); // R11

  AST_VEC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_rd && vec_val != '0 && !flag_wr && edge_rise == '0)
      |=> $countones(flag_q) == $countones($past(flag_q)) - 1); // R11

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ($past(edge_rise) & ~flag_q) == '0); // R12
endmodule

bind gpio_pcint_port gpio_pcint_chk #(.W(W), .DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_en_i   (bus_en_i),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .pad_oe_o   (pad_oe_o),
  .periph_in_o(periph_in_o),
  .irq_o      (irq_o),
  .fsel_q     (fsel_q),
  .flag_q     (flag_q),
  .edge_rise  (edge_rise),
  .vec_val    (vec_val)
);

// File: tb/tb_gpio_pcint_port.sv
module tb_gpio_pcint_port;
  import gpio_pcint_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_en_i = 1'b0, bus_we_i = 1'b0;
  logic [3:0]  bus_addr_i = '0;
  logic [15:0] bus_wdata_i = '0, bus_rdata_o;
  logic [7:0]  pad_in_i = '0, pad_out_o, pad_oe_o, pad_pull_en_o, pad_pull_up_o;
  logic [7:0]  periph_out_i = '0, periph_in_o;
  logic        irq_o;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic [15:0] rv;

  always #2.5 clk_i = ~clk_i;

  gpio_pcint_port dut (.*);

  // {addr, write data, expected read}
  localparam logic [35:0] TBL [6] = '{
    {4'd1, 16'hA5C3, 16'h00C3},
    {4'd2, 16'h1234, 16'h0034},
    {4'd4, 16'hFFFF, 16'h00FF},
    {4'd3, 16'h0F0F, 16'h000F},
    {4'd6, 16'h8180, 16'h0080},
    {4'd5, 16'h0000, 16'h0000}
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk_i);
    bus_en_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_en_i = 1'b0; bus_we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk_i);
    bus_en_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = a;
    #1 d = bus_rdata_o;
    @(negedge clk_i);
    bus_en_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; pad_in_i = '0; periph_out_i = '0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk_i);
  endtask

  initial begin
    repeat (20000) @(negedge clk_i);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 oe", 16'(pad_oe_o), 16'h0);
    chk("R1 out", 16'(pad_out_o), 16'h0);
    chk("R1 pull", 16'({pad_pull_en_o, pad_pull_up_o}), 16'h0);
    chk("R1 irq/periph", 16'({irq_o, periph_in_o}), 16'h0);
    for (int a = 1; a <= 8; a++) begin
      rd(4'(a), rv);
      chk("R1 regs", rv, 16'h0);
    end

    // R2 register readback from the table
    for (int i = 0; i < 6; i++) begin
      wr(TBL[i][35:32], TBL[i][31:16]);
      rd(TBL[i][35:32], rv);
      chk("R2 readback", rv, TBL[i][15:0]);
    end

    do_reset();
    // R2 and R5: GPIO output path and pulls
    wr(4'(ADDR_OUT), 16'h005A);
    wr(4'(ADDR_DIR), 16'h00F0);
    wr(4'(ADDR_PULL), 16'h000F);
    chk("R2 oe", 16'(pad_oe_o), 16'h00F0);
    chk("R2 out", 16'(pad_out_o), 16'h005A);
    chk("R5 pull_en", 16'(pad_pull_en_o), 16'h000F);
    chk("R5 pull_up", 16'(pad_pull_up_o), 16'h005A);

    // R3 peripheral ownership
    periph_out_i = 8'h33;
    wr(4'(ADDR_FSEL), 16'h003C);
    chk("R3 out mux", 16'(pad_out_o), 16'h0072);
    chk("R3 oe", 16'(pad_oe_o), 16'h00F0);
    @(negedge clk_i); pad_in_i = 8'h3C;
    settle();
    chk("R3 periph_in", 16'(periph_in_o), 16'h003C);
    rd(4'(ADDR_IN), rv);
    chk("R6 input readable", rv, 16'h003C);
    rd(4'(ADDR_FLAG), rv);
    chk("R8 no flag when owned", rv, 16'h0000);

    // R4 hold when released
    wr(4'(ADDR_FSEL), 16'h000C);
    @(negedge clk_i); pad_in_i = 8'h00;
    settle();
    chk("R4 periph hold", 16'(periph_in_o), 16'h0030);
    rd(4'(ADDR_IN), rv);
    chk("R6 input", rv, 16'h0000);
    rd(4'(ADDR_FLAG), rv);
    chk("R7 falling ignored", rv, 16'h0000);

    do_reset();
    // R7 edge detection
    @(negedge clk_i); pad_in_i = 8'h01;
    settle();
    rd(4'(ADDR_FLAG), rv);
    chk("R7 rising", rv, 16'h0001);
    chk("R10 irq off when disabled", 16'(irq_o), 16'h0);
    wr(4'(ADDR_DIR), 16'h0001);
    @(negedge clk_i); pad_in_i = 8'h03;
    settle();
    rd(4'(ADDR_FLAG), rv);
    chk("R7 output mode", rv, 16'h0003);
    wr(4'(ADDR_EDGE), 16'h0008);
    settle();
    rd(4'(ADDR_FLAG), rv);
    chk("R7 polarity write", rv, 16'h000B);
    wr(4'(ADDR_FLAG), 16'h0000);
    rd(4'(ADDR_FLAG), rv);
    chk("R9 clear", rv, 16'h0000);
    @(negedge clk_i); pad_in_i = 8'h0B;
    settle();
    rd(4'(ADDR_FLAG), rv);
    chk("R7 rise ignored at polarity 1", rv, 16'h0000);
    @(negedge clk_i); pad_in_i = 8'h03;
    settle();
    rd(4'(ADDR_FLAG), rv);
    chk("R7 falling", rv, 16'h0008);

    // R9 software set
    wr(4'(ADDR_FLAG), 16'h00A0);
    rd(4'(ADDR_FLAG), rv);
    chk("R9 write", rv, 16'h00A0);

    // R10 and R11
    rd(4'(ADDR_VEC), rv);
    chk("R11 none enabled", rv, 16'h0000);
    wr(4'(ADDR_IE), 16'h00A8);
    chk("R10 irq on", 16'(irq_o), 16'h1);
    rd(4'(ADDR_VEC), rv);
    chk("R11 lowest", rv, 16'd12);
    rd(4'(ADDR_VEC), rv);
    chk("R11 next", rv, 16'd16);
    rd(4'(ADDR_FLAG), rv);
    chk("R11 cleared", rv, 16'h0000);
    chk("R10 irq off", 16'(irq_o), 16'h0);
    wr(4'(ADDR_FLAG), 16'h0021);
    wr(4'(ADDR_IE), 16'h0020);
    rd(4'(ADDR_VEC), rv);
    chk("R11 masked low bit", rv, 16'd12);
    rd(4'(ADDR_FLAG), rv);
    chk("R11 exact clear", rv, 16'h0001);

    do_reset();
    // R12 set beats clear in same cycle
    wr(4'(ADDR_FLAG), 16'h00FF);
    @(negedge clk_i);
    bus_en_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = 4'(ADDR_EDGE); bus_wdata_i = 16'h0004;
    @(negedge clk_i);
    bus_addr_i = 4'(ADDR_FLAG); bus_wdata_i = 16'h0000;
    @(negedge clk_i);
    bus_en_i = 1'b0; bus_we_i = 1'b0;
    rd(4'(ADDR_FLAG), rv);
    chk("R12 set wins", rv, 16'h0004);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule